// File: doc/BRIEF.md
# Serial-programmed ten-way clock gate

This block takes one clock input and gives out ten gated copies of it, in three groups of four, four and two lanes. Each lane can be turned off from a two-wire serial host. The block is a write-only slave receiver on that bus. The host addresses it, sends two header bytes that are discarded, and then sends up to three enable bytes. Those bytes land in three enable registers in a fixed order, with no register addressing. A lane whose enable bit is clear is held low. A lane whose enable bit is set follows the clock input.

A global enable pin sits above the register contents. When that pin is low, every lane's tri-state enable drops, so the pad goes high-impedance. The serial lines are oversampled by a system clock through synchronizers. The block pulls the data line low to acknowledge. A lane only switches between gated and running while the clock input is low, so reprogramming never cuts a pulse short. The system reset is synchronous and active high.

Top module: `clkfan_i2c_ctrl`

## Requirements
- R1: After reset, all three enable registers hold all ones. Every lane then follows `ref_clk` while `out_en` is high, and `sda_pull` is 0.
- R2: A first byte of 0xD2 is acknowledged: `sda_pull` is 1 while SCL is high in the ninth clock. That byte is the seven address bits 1101001 followed by a 0 in the direction bit.
- R3: A first byte with any other address, or with the direction bit at 1 (e.g. 0xD3), is not acknowledged. The bytes that follow it until the next STOP are not acknowledged and change no lane.
- R4: In a matched transfer, the second byte and the third byte are each acknowledged and then discarded.
- R5: In a matched transfer, bytes four, five and six load enable registers 0, 1 and 2 in that order, and each of these bytes is acknowledged.
- R6: A STOP after byte four or after byte five leaves the registers that were not yet reached unchanged.
- R7: Any byte after the sixth is not acknowledged and has no effect.
- R8: A START that arrives before the STOP of a transfer is not taken as a new transaction. Every byte from then on is unacknowledged and has no effect until the next STOP.
- R9: The lanes map to register bits as follows:
  - lanes 3..0 to register 0 bits 3..0;
  - lanes 7..4 to register 1 bits 7..4;
  - lane 8 to register 2 bit 6, and lane 9 to register 2 bit 7.
  
  A lane whose bit is 0 stays low, and a lane whose bit is 1 follows `ref_clk`. The other register bits have no effect.
- R10: While `out_en` is low, all `clk_oe` bits and all `clk_out` bits are 0. While `out_en` is high, all `clk_oe` bits are 1.
- R11: A new enable value reaches a lane only while `ref_clk` is low. Every lane edge therefore coincides with a `ref_clk` edge of the same direction.
- R12: `sda_pull` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_pull | output | 1 | 1 = pull the data line low (acknowledge) |
| ref_clk | input | 1 | Clock input to be distributed |
| out_en | input | 1 | Global output enable, high = lanes driven |
| clk_out | output | 10 | Gated clock lanes |
| clk_oe | output | 10 | Per-lane tri-state enable, 1 = drive |

## Verification
A receiver that loses count of bits or bytes shows up at the ports in two ways. An acknowledge is missing or appears in the wrong ninth clock, which is visible during the byte itself. Otherwise an enable byte lands in the wrong register, which appears as a wrong lane pattern within one `ref_clk` period after the STOP. A gate that takes a new value while `ref_clk` is high shows up as a lane edge that does not line up with a `ref_clk` edge. A stuck skip or abort state leaves later valid transfers unacknowledged and their lanes unchanged.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;
    localparam int NUM_REGS  = 3;
    localparam int REG_W     = 8;
    localparam int NUM_OUT   = 10;
    localparam int HDR_BYTES = 3;            // address, command, count
    localparam int LAST_BYTE = HDR_BYTES + NUM_REGS;
    localparam int IDX_W     = $clog2(LAST_BYTE + 1);
    localparam int BIT_W     = $clog2(REG_W + 1);
    localparam logic [6:0] DEV_ADDR = 7'b1101001;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_SKIP
    } rx_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    typedef logic [NUM_REGS-1:0][REG_W-1:0] reg_bank_t;

    // lanes 9..0 from register bits; remaining bits are reserved
    function automatic logic [NUM_OUT-1:0] map_enables(input reg_bank_t r);
        return {r[2][7:6], r[1][7:4], r[0][3:0]};
    endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import clkfan_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_p;
    logic              sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_in};
            sda_q <= {sda_q[STAGES-2:0], sda_in};
            scl_p <= scl_q[STAGES-1];
            sda_p <= sda_q[STAGES-1];
        end
    end

    always_comb begin
        ev.scl      = scl_q[STAGES-1];
        ev.sda      = sda_q[STAGES-1];
        ev.scl_rise = ev.scl & ~scl_p;
        ev.scl_fall = ~ev.scl & scl_p;
        ev.start    = ev.scl & scl_p & sda_p & ~ev.sda;
        ev.stop     = ev.scl & scl_p & ~sda_p & ev.sda;
    end
endmodule

// File: rtl/i2c_wr_slave.sv
module i2c_wr_slave
    import clkfan_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  bus_ev_t   ev,
    output logic      sda_pull,
    output reg_bank_t regs
);
    localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(REG_W - 1);
    localparam logic [BIT_W-1:0] FULL_BITS = BIT_W'(REG_W);
    localparam logic [IDX_W-1:0] HDR_END   = IDX_W'(HDR_BYTES);
    localparam logic [IDX_W-1:0] DATA_END  = IDX_W'(LAST_BYTE);

    rx_state_e        state;
    logic [BIT_W-1:0] bit_cnt;
    logic [IDX_W-1:0] byte_idx;
    logic [REG_W-1:0] shreg;
    logic             ack_pend;
    logic [REG_W-1:0] full;

    assign full = {shreg[REG_W-2:0], ev.sda};

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            byte_idx <= '0;
            shreg    <= '0;
            ack_pend <= 1'b0;
            sda_pull <= 1'b0;
            regs     <= '1;
        end else if (ev.stop) begin
            state    <= ST_IDLE;
            sda_pull <= 1'b0;
        end else if (ev.start) begin
            sda_pull <= 1'b0;
            if (state == ST_IDLE) begin
                state    <= ST_RX;
                bit_cnt  <= '0;
                byte_idx <= '0;
                ack_pend <= 1'b0;
            end else begin
                state <= ST_SKIP;       // repeated start: abort until STOP
            end
        end else begin
            case (state)
                ST_RX: begin
                    if (ev.scl_rise && bit_cnt < FULL_BITS) begin
                        shreg   <= full;
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == LAST_BIT) begin
                            if (byte_idx == '0) begin
                                ack_pend <= (full[7:1] == DEV_ADDR) && !full[0];
                            end else if (byte_idx < HDR_END) begin
                                ack_pend <= 1'b1;
                            end else if (byte_idx < DATA_END) begin
                                ack_pend <= 1'b1;
                                for (int k = 0; k < NUM_REGS; k++) begin
                                    if (byte_idx == IDX_W'(HDR_BYTES + k)) begin
                                        regs[k] <= full;
                                    end
                                end
                            end else begin
                                ack_pend <= 1'b0;
                            end
                        end
                    end else if (ev.scl_fall && bit_cnt == FULL_BITS) begin
                        if (ack_pend) begin
                            sda_pull <= 1'b1;
                            state    <= ST_ACK;
                        end else begin
                            state <= ST_SKIP;
                        end
                    end
                end
                ST_ACK: begin
                    if (ev.scl_fall) begin
                        sda_pull <= 1'b0;
                        state    <= ST_RX;
                        bit_cnt  <= '0;
                        byte_idx <= byte_idx + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/clk_gate_bank.sv
module clk_gate_bank #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ref_clk,
    input  logic         out_en,
    input  logic [N-1:0] en_req,
    output logic [N-1:0] en_live,
    output logic [N-1:0] clk_out,
    output logic [N-1:0] clk_oe
);
    for (genvar i = 0; i < N; i++) begin : g_lane
        logic eff;
        always_ff @(posedge clk) begin
            if (rst) begin
                eff <= 1'b1;
            end else if (!ref_clk) begin
                eff <= en_req[i];
            end
        end
        assign en_live[i] = eff;
        assign clk_out[i] = ref_clk & eff & out_en;
        assign clk_oe[i]  = out_en;
    end
endmodule

// File: rtl/clkfan_i2c_ctrl.sv
module clkfan_i2c_ctrl
    import clkfan_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               sda_pull,
    input  logic               ref_clk,
    input  logic               out_en,
    output logic [NUM_OUT-1:0] clk_out,
    output logic [NUM_OUT-1:0] clk_oe
);
    bus_ev_t            bus_ev;
    reg_bank_t          regs;
    logic [NUM_OUT-1:0] en_req;
    logic [NUM_OUT-1:0] en_live;
    logic               scl_sync;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (bus_ev)
    );

    i2c_wr_slave u_slave (
        .clk      (clk),
        .rst      (rst),
        .ev       (bus_ev),
        .sda_pull (sda_pull),
        .regs     (regs)
    );

    assign en_req   = map_enables(regs);
    assign scl_sync = bus_ev.scl;

    clk_gate_bank #(.N(NUM_OUT)) u_gate (
        .clk     (clk),
        .rst     (rst),
        .ref_clk (ref_clk),
        .out_en  (out_en),
        .en_req  (en_req),
        .en_live (en_live),
        .clk_out (clk_out),
        .clk_oe  (clk_oe)
    );
endmodule

// File: rtl/clkfan_i2c_chk.sv
module clkfan_i2c_chk #(
    parameter int N = 10
) (
    input logic         clk,
    input logic         rst,
    input logic         scl_s,
    input logic         sda_pull,
    input logic         ref_clk,
    input logic         out_en,
    input logic [N-1:0] en_live,
    input logic [N-1:0] clk_out,
    input logic [N-1:0] clk_oe
);
    assert_ack_scl_low_R12: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_pull) |-> !scl_s);

    assert_oe_needs_pin_R10: assert property (@(posedge clk) disable iff (rst)
        (clk_oe != '0) |-> out_en);

    assert_hiz_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !out_en |-> (clk_out == '0));

    assert_no_runt_R11: assert property (@(posedge clk) disable iff (rst)
        !$stable(en_live) |-> !$past(ref_clk));

    assert_high_needs_ref_R9: assert property (@(posedge clk) disable iff (rst)
        (clk_out != '0) |-> ref_clk);
endmodule

bind clkfan_i2c_ctrl clkfan_i2c_chk #(.N(clkfan_pkg::NUM_OUT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_s    (scl_sync),
    .sda_pull (sda_pull),
    .ref_clk  (ref_clk),
    .out_en   (out_en),
    .en_live  (en_live),
    .clk_out  (clk_out),
    .clk_oe   (clk_oe)
);

// File: tb/clkfan_i2c_ctrl_tb.sv
`timescale 1ns/1ps
module clkfan_i2c_ctrl_tb;
    localparam int Q = 12;              // quarter bit time in clk cycles

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_drv = 1'b1;
    logic       sda_drv = 1'b1;
    logic       ref_clk = 1'b0;
    logic       out_en = 1'b1;
    logic       sda_pull;
    logic [9:0] clk_out;
    logic [9:0] clk_oe;
    logic       sda_line;

    int n_chk = 0;
    int n_fail = 0;
    int runt_err = 0;
    int pull_err = 0;
    bit done = 0;

    logic [7:0] exp_reg [0:2];

    always #5 clk = ~clk;
    initial begin
        #2;
        forever #85 ref_clk = ~ref_clk;
    end

    assign sda_line = sda_drv & ~sda_pull;

    clkfan_i2c_ctrl u_dut (
        .clk      (clk),
        .rst      (rst),
        .scl_in   (scl_drv),
        .sda_in   (sda_line),
        .sda_pull (sda_pull),
        .ref_clk  (ref_clk),
        .out_en   (out_en),
        .clk_out  (clk_out),
        .clk_oe   (clk_oe)
    );

    // R11 / R12 monitors sampled away from the active edge
    logic [9:0] p_out;
    logic       p_ref, p_oe, p_pull;
    initial begin
        p_out = '0; p_ref = 0; p_oe = 0; p_pull = 0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (out_en && p_oe) begin
                    for (int i = 0; i < 10; i++) begin
                        if (clk_out[i] && !p_out[i] && !(ref_clk && !p_ref)) runt_err++;
                        if (!clk_out[i] && p_out[i] && !(!ref_clk && p_ref)) runt_err++;
                    end
                end
                if (sda_pull != p_pull && scl_drv) pull_err++;
            end
            p_out = clk_out; p_ref = ref_clk; p_oe = out_en; p_pull = sda_pull;
        end
    end

    function automatic logic [9:0] lane_map(input logic [7:0] r0, r1, r2);
        return {r2[7], r2[6], r1[7:4], r0[3:0]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1; scl_drv = 1; wq(1);
        sda_drv = 0; wq(1);
        scl_drv = 0; wq(1);
    endtask

    task automatic bus_rstart();
        sda_drv = 1; wq(1);
        scl_drv = 1; wq(1);
        sda_drv = 0; wq(1);
        scl_drv = 0; wq(1);
    endtask

    task automatic bus_stop();
        sda_drv = 0; wq(1);
        scl_drv = 1; wq(1);
        sda_drv = 1; wq(1);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i]; wq(1);
            scl_drv = 1; wq(2);
            scl_drv = 0; wq(1);
        end
        sda_drv = 1; wq(1);
        scl_drv = 1; wq(1);
        ack = sda_pull;
        wq(1);
        scl_drv = 0; wq(1);
    endtask

    // full transfer; returns ack bits and updates the reference model
    task automatic xfer(input logic [7:0] bytes [0:6], input int n, output logic [6:0] acks);
        logic a;
        acks = '0;
        bus_start();
        for (int i = 0; i < n; i++) begin
            send_byte(bytes[i], a);
            acks[i] = a;
        end
        bus_stop();
        if (bytes[0] == 8'hD2) begin
            for (int i = 3; i < n && i < 6; i++) exp_reg[i-3] = bytes[i];
        end
    endtask

    function automatic logic [6:0] exp_acks(input logic [7:0] first, input int n);
        logic [6:0] r = '0;
        if (first == 8'hD2)
            for (int i = 0; i < n && i < 6; i++) r[i] = 1'b1;
        return r;
    endfunction

    task automatic check_lanes(input string tag);
        logic [9:0] e;
        e = lane_map(exp_reg[0], exp_reg[1], exp_reg[2]);
        repeat (2) @(posedge ref_clk);
        repeat (3) @(negedge clk);
        chk({tag, " lanes high"}, {22'd0, clk_out}, {22'd0, (out_en ? e : 10'h0)});
        chk({tag, " oe"}, {22'd0, clk_oe}, {22'd0, {10{out_en}}});
        @(negedge ref_clk);
        repeat (3) @(negedge clk);
        chk({tag, " lanes low"}, {22'd0, clk_out}, 32'd0);
    endtask

    logic [7:0] bb [0:6];
    logic [6:0] ak;

    initial begin
        void'($urandom(32'd4711));
        exp_reg[0] = 8'hFF; exp_reg[1] = 8'hFF; exp_reg[2] = 8'hFF;
        repeat (5) @(negedge clk);
        rst = 0;
        repeat (3) @(negedge clk);
        chk("R1 sda released", {31'd0, sda_pull}, 32'd0);
        check_lanes("R1 reset");

        // R2 R4 R5 R9 full write
        bb = '{8'hD2, 8'h00, 8'h03, 8'h05, 8'hA0, 8'h40, 8'h00};
        xfer(bb, 6, ak);
        chk("R2 R4 R5 acks", {25'd0, ak}, 32'h3F);
        check_lanes("R5 R9 full write");

        // R6 stop after byte four; R9 reserved bits
        bb = '{8'hD2, 8'h11, 8'h22, 8'hF0, 8'h00, 8'h00, 8'h00};
        xfer(bb, 4, ak);
        chk("R6 acks", {25'd0, ak}, 32'h0F);
        check_lanes("R6 R9 partial byte4");

        bb = '{8'hD2, 8'h11, 8'h22, 8'h0F, 8'hF0, 8'h00, 8'h00};
        xfer(bb, 5, ak);
        check_lanes("R6 partial byte5");

        // R3 wrong address
        bb = '{8'hD0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        xfer(bb, 6, ak);
        chk("R3 wrong addr acks", {25'd0, ak}, 32'h0);
        check_lanes("R3 wrong addr lanes");

        // R3 read direction
        bb = '{8'hD3, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        xfer(bb, 5, ak);
        chk("R3 read acks", {25'd0, ak}, 32'h0);
        check_lanes("R3 read lanes");

        // R7 seventh byte
        bb = '{8'hD2, 8'h00, 8'h00, 8'h0F, 8'hF0, 8'hC0, 8'h00};
        xfer(bb, 7, ak);
        chk("R7 acks", {25'd0, ak}, 32'h3F);
        check_lanes("R7 lanes");

        // R8 repeated start
        begin
            logic a;
            logic [3:0] ra;
            bus_start();
            send_byte(8'hD2, a);
            send_byte(8'h00, a);
            bus_rstart();
            send_byte(8'hD2, ra[0]);
            send_byte(8'h00, ra[1]);
            send_byte(8'h00, ra[2]);
            send_byte(8'h00, ra[3]);
            bus_stop();
            chk("R8 acks after rstart", {28'd0, ra}, 32'h0);
            check_lanes("R8 lanes");
        end

        // R10 global enable low
        out_en = 0;
        repeat (3) @(negedge clk);
        chk("R10 oe low", {22'd0, clk_oe}, 32'd0);
        check_lanes("R10 hiz");
        out_en = 1;
        repeat (3) @(negedge clk);
        chk("R10 oe high", {22'd0, clk_oe}, 32'h3FF);

        // random transfers
        for (int t = 0; t < 10; t++) begin
            int n;
            n = 4 + int'($urandom % 4);
            for (int i = 0; i < 7; i++) bb[i] = 8'($urandom);
            bb[0] = (($urandom % 4) == 0) ? 8'hD0 : 8'hD2;
            xfer(bb, n, ak);
            chk("R2 R3 R5 R7 random acks", {25'd0, ak}, {25'd0, exp_acks(bb[0], n)});
            check_lanes("R5 R9 random lanes");
        end

        chk("R11 lane edges align", runt_err, 0);
        chk("R12 pull changes scl low", pull_err, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule